// File: doc/BRIEF.md
# Three-Wire Audio Control Register Receiver

This block is the slave end of a three-wire control port made of an active-low chip select, a serial clock and a data line. It brings the three pins and an active-low standby pin into the system clock domain. During a frame it shifts in a 16-bit control word, least significant bit first. When the chip select rises, it commits the word to a control register, but only if exactly sixteen serial clock rises were seen in that frame.

The register drives decoded control outputs for an audio front end:
- a low-pass cut-off select;
- six power enables, which are active-low in the word and active-high at the ports;
- a line mute;
- a two-bit filter-path mode;
- a five-bit volume code with a mute flag.

After reset or after standby is released, the first frame is treated as a dummy and cannot change the register. The system clock must run at least eight times faster than the serial clock.

Top module: `audio_ctl_rx`

## Requirements
- R1: After reset, `ctl_word` reads 16'h0500 (only bits 8 and 10 set). The decoded outputs then follow from that word: line and speaker power off, line muted, volume 0, playback-analog mode and the wide filter.
- R2: The first complete frame after reset or after standby release is discarded, and the register keeps its value.
- R3: A later frame of exactly 16 clocks is loaded LSB first on the chip-select rising edge. The first data bit sent becomes bit 0 of `ctl_word`.
- R4: A frame with 15 or 17 serial clock rises leaves the register unchanged.
- R5: Each power enable output is the inverse of its word bit: bit 2 drives `chg_en`, bit 3 `mic_en`, bit 4 `alc_en`, bit 7 `rec_en`, bit 8 `line_en` and bit 10 `spk_en`.
- R6: `lpf_narrow` equals word bit 1. A 1 selects the 4 kHz cut-off and a 0 selects the 11 kHz cut-off.
- R7: `line_mute` is 1 exactly when word bit 9 is 0.
- R8: `filt_mode` is 2'b10 (record) whenever bit 5 is 1, whatever bit 6 holds. With bit 5 at 0 it is 2'b00 (playback analog) when bit 6 is 0 and 2'b01 (playback digital) when bit 6 is 1.
- R9: `vol_code` equals word bits 15:11, with bit 11 weighted 1 and bit 15 weighted 16. `vol_mute` is 1 exactly when that code is 0.
- R10: Driving `standby_n` low returns the register to 16'h0500. After release the dummy-frame gate is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Asynchronous standby pin, low = standby |
| cs_n | input | 1 | Serial chip select, low during a frame |
| sclk | input | 1 | Serial clock, data sampled on its rise |
| sdata | input | 1 | Serial data, LSB first |
| ctl_word | output | 16 | Committed control register |
| lpf_narrow | output | 1 | 1 = 4 kHz cut-off, 0 = 11 kHz |
| chg_en | output | 1 | Reference charging enable |
| mic_en | output | 1 | Microphone amplifier enable |
| alc_en | output | 1 | Level-control amplifier enable |
| rec_en | output | 1 | Record block enable |
| line_en | output | 1 | Line amplifier enable |
| spk_en | output | 1 | Speaker amplifier enable |
| line_mute | output | 1 | Line output muted |
| filt_mode | output | 2 | 00 playback analog, 01 playback digital, 10 record |
| vol_code | output | 5 | Volume code, 0 = minimum |
| vol_mute | output | 1 | Volume code is zero |

## Verification
The bench sends an all-ones dummy frame first. A design that skipped the dummy gate would load that frame and turn every supply off. Short and long frames of 15 and 17 clocks are sent to catch a receiver that commits on any chip-select rise, or that keeps only the last sixteen bits. All 32 volume codes are swept with varied low bits, and every combination of the two mode bits is sent, so that a reversed bit order, an inverted enable or a mode decode that uses the don't-care bit shows up. A standby pulse follows, to check that the defaults come back and that the gate discards the next frame again.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int FRAME_BITS = 16;
  localparam int VOL_W      = 5;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  localparam int B_LPF   = 1;
  localparam int B_CHG   = 2;
  localparam int B_MIC   = 3;
  localparam int B_ALC   = 4;
  localparam int B_MODEA = 5;
  localparam int B_MODEB = 6;
  localparam int B_REC   = 7;
  localparam int B_LINE  = 8;
  localparam int B_LMUTE = 9;
  localparam int B_SPK   = 10;
  localparam int B_VOL   = 11;

  localparam logic [FRAME_BITS-1:0] WORD_DEFAULT = 16'h0500;

  typedef enum logic [1:0] {
    FM_PB_ANALOG  = 2'b00,
    FM_PB_DIGITAL = 2'b01,
    FM_REC        = 2'b10
  } filt_mode_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int              WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import audio_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  cs_act,
  input  logic                  cs_start,
  input  logic                  sclk_rise,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] shreg,
  output logic [CNT_W-1:0]      cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_start) begin
      cnt <= '0;
    end else if (cs_act && sclk_rise) begin
      shreg <= {din, shreg[FRAME_BITS-1:1]};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  // Between frames nothing moves in the shifter.
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && !cs_start && !clr) |=> ($stable(cnt) && $stable(shreg)));

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_SAT && !cs_start && !clr) |=> (cnt == CNT_SAT));
endmodule

// File: rtl/ctl_register.sv
module ctl_register
  import audio_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stby_ok,
  input  logic                  cs_end,
  input  logic [FRAME_BITS-1:0] shreg,
  input  logic [CNT_W-1:0]      cnt,
  output logic [FRAME_BITS-1:0] word_q
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst || !stby_ok) begin
      word_q <= WORD_DEFAULT;
      armed  <= 1'b0;
    end else if (cs_end) begin
      armed <= 1'b1;
      if (armed && cnt == CNT_FULL) word_q <= shreg;
    end
  end

  p_dummy_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (stby_ok && cs_end && !armed) |=> $stable(word_q));

  p_bad_count_r4: assert property (@(posedge clk) disable iff (rst)
    (stby_ok && cs_end && cnt != CNT_FULL) |=> $stable(word_q));

  p_standby_default_r10: assert property (@(posedge clk) disable iff (rst)
    !stby_ok |=> (word_q == WORD_DEFAULT && !armed));
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import audio_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  lpf_narrow,
  output logic                  chg_en,
  output logic                  mic_en,
  output logic                  alc_en,
  output logic                  rec_en,
  output logic                  line_en,
  output logic                  spk_en,
  output logic                  line_mute,
  output logic [1:0]            filt_mode,
  output logic [VOL_W-1:0]      vol_code,
  output logic                  vol_mute
);
  filt_mode_t       mode_d;
  logic [VOL_W-1:0] vol_d;

  always_comb begin
    if (word[B_MODEA])      mode_d = FM_REC;
    else if (word[B_MODEB]) mode_d = FM_PB_DIGITAL;
    else                    mode_d = FM_PB_ANALOG;
    vol_d = word[B_VOL +: VOL_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lpf_narrow <= WORD_DEFAULT[B_LPF];
      chg_en     <= ~WORD_DEFAULT[B_CHG];
      mic_en     <= ~WORD_DEFAULT[B_MIC];
      alc_en     <= ~WORD_DEFAULT[B_ALC];
      rec_en     <= ~WORD_DEFAULT[B_REC];
      line_en    <= ~WORD_DEFAULT[B_LINE];
      spk_en     <= ~WORD_DEFAULT[B_SPK];
      line_mute  <= ~WORD_DEFAULT[B_LMUTE];
      filt_mode  <= FM_PB_ANALOG;
      vol_code   <= '0;
      vol_mute   <= 1'b1;
    end else begin
      lpf_narrow <= word[B_LPF];
      chg_en     <= ~word[B_CHG];
      mic_en     <= ~word[B_MIC];
      alc_en     <= ~word[B_ALC];
      rec_en     <= ~word[B_REC];
      line_en    <= ~word[B_LINE];
      spk_en     <= ~word[B_SPK];
      line_mute  <= ~word[B_LMUTE];
      filt_mode  <= mode_d;
      vol_code   <= vol_d;
      vol_mute   <= (vol_d == '0);
    end
  end

  p_lpf_follow_r6: assert property (@(posedge clk) disable iff (rst)
    word[B_LPF] |=> lpf_narrow);

  p_rec_mode_r8: assert property (@(posedge clk) disable iff (rst)
    word[B_MODEA] |=> (filt_mode == FM_REC));

  p_vol_mute_r9: assert property (@(posedge clk) disable iff (rst)
    vol_mute |-> (vol_code == '0));
endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
  import audio_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        standby_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdata,
  output logic [15:0] ctl_word,
  output logic        lpf_narrow,
  output logic        chg_en,
  output logic        mic_en,
  output logic        alc_en,
  output logic        rec_en,
  output logic        line_en,
  output logic        spk_en,
  output logic        line_mute,
  output logic [1:0]  filt_mode,
  output logic [4:0]  vol_code,
  output logic        vol_mute
);
  localparam int PINS = 4;
  localparam int P_CS = 0, P_CK = 1, P_DT = 2, P_SB = 3;
  localparam logic [PINS-1:0] PIN_IDLE = 4'b1001;

  logic [PINS-1:0]       lvl, rse, fll;
  logic [FRAME_BITS-1:0] shreg, word_q;
  logic [CNT_W-1:0]      cnt;

  pin_sync #(.WIDTH(PINS), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .pin({standby_n, sdata, sclk, cs_n}),
    .level(lvl), .rise(rse), .fall(fll)
  );

  frame_shifter u_shift (
    .clk(clk), .rst(rst), .clr(!lvl[P_SB]),
    .cs_act(!lvl[P_CS]), .cs_start(fll[P_CS]),
    .sclk_rise(rse[P_CK]), .din(lvl[P_DT]),
    .shreg(shreg), .cnt(cnt)
  );

  ctl_register u_reg (
    .clk(clk), .rst(rst), .stby_ok(lvl[P_SB]),
    .cs_end(rse[P_CS]), .shreg(shreg), .cnt(cnt),
    .word_q(word_q)
  );

  ctl_decode u_dec (
    .clk(clk), .rst(rst), .word(word_q),
    .lpf_narrow(lpf_narrow), .chg_en(chg_en), .mic_en(mic_en),
    .alc_en(alc_en), .rec_en(rec_en), .line_en(line_en),
    .spk_en(spk_en), .line_mute(line_mute), .filt_mode(filt_mode),
    .vol_code(vol_code), .vol_mute(vol_mute)
  );

  assign ctl_word = word_q;

  p_reset_default_r1: assert property (@(posedge clk)
    $past(rst) |-> (ctl_word == WORD_DEFAULT));
endmodule

// File: tb/tb_audio_ctl_rx.sv
module tb_audio_ctl_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [15:0] ctl_word;
  logic lpf_narrow, chg_en, mic_en, alc_en, rec_en, line_en, spk_en, line_mute, vol_mute;
  logic [1:0] filt_mode;
  logic [4:0] vol_code;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  audio_ctl_rx dut (
    .clk(clk), .rst(rst), .standby_n(standby_n), .cs_n(cs_n), .sclk(sclk),
    .sdata(sdata), .ctl_word(ctl_word), .lpf_narrow(lpf_narrow),
    .chg_en(chg_en), .mic_en(mic_en), .alc_en(alc_en), .rec_en(rec_en),
    .line_en(line_en), .spk_en(spk_en), .line_mute(line_mute),
    .filt_mode(filt_mode), .vol_code(vol_code), .vol_mute(vol_mute)
  );

  function automatic logic [15:0] expect_dec(input logic [15:0] w);
    logic [1:0] m;
    m = w[5] ? 2'b10 : (w[6] ? 2'b01 : 2'b00);
    return {w[1], ~w[2], ~w[3], ~w[4], ~w[7], ~w[8], ~w[10], ~w[9],
            m, w[15:11], (w[15:11] == 5'd0)};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [15:0] w);
    check({tag, " word"}, ctl_word, w);
    check({tag, " decode"},
          {lpf_narrow, chg_en, mic_en, alc_en, rec_en, line_en, spk_en,
           line_mute, filt_mode, vol_code, vol_mute}, expect_dec(w));
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[i] : 1'b0;
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cur;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    cur = 16'h0500;
    check_state("R1 reset default", cur);

    send(16'hFFFF, 16);
    check_state("R2 dummy frame ignored", cur);

    cur = 16'h1234;
    send(cur, 16);
    check_state("R3 first real frame", cur);

    send(16'hBEEF, 15);
    check_state("R4 15-clock frame ignored", cur);
    send(16'hBEEF, 17);
    check_state("R4 17-clock frame ignored", cur);

    for (int v = 0; v < 32; v++) begin
      logic [10:0] lo;
      lo = 11'((v * 1237 + 341) & 11'h7FF);
      cur = {5'(v), lo};
      send(cur, 16);
      check_state("R9 R5 R6 R7 volume sweep", cur);
    end

    for (int m = 0; m < 4; m++) begin
      cur = 16'hA38A | 16'(m << 5);
      send(cur, 16);
      check_state("R8 filter mode", cur);
    end

    cur = 16'h0004;
    send(cur, 16);
    check_state("R5 single enable bit", cur);
    cur = 16'h0202;
    send(cur, 16);
    check_state("R6 R7 narrow unmuted", cur);

    standby_n = 1'b0;
    wait_clk(10);
    cur = 16'h0500;
    check_state("R10 standby default", cur);
    standby_n = 1'b1;
    wait_clk(10);
    send(16'h7E01, 16);
    check_state("R10 dummy rearmed", cur);
    cur = 16'h7E01;
    send(cur, 16);
    check_state("R10 load after rearm", cur);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule